// File: doc/BRIEF.md
# Protected SRAM Bus Interface

This block connects a byte-wide static memory to an asynchronous-style bus. The bus has active-low chip enable, write enable and output enable strobes. The block samples those strobes with a fast system clock and decodes them into read and write operations on a synchronous RAM model.

Reads put the stored byte on a data bus that the block drives only when it has to. The bus is modelled as a data value plus a drive enable.

A write window opens when chip enable and write enable are both low, and it closes when either one rises. The byte is committed when the window closes, and a one-cycle completion strobe marks it.

A write-protect input comes from a power supervisor. While it is high the block ignores the bus completely and floats its data outputs.

Top module: `psram_bus_if`

## Requirements
- R1: The address port is 17 bits and the data path is 8 bits. The array holds 2**MEM_AW bytes (the default is 1024; 17 gives the full 131,072). Addresses are taken modulo the array size by keeping the low MEM_AW bits.
- R2: A read is decoded when the synchronised strobes show write enable high and both chip enable and output enable low, and write-protect is low. Three clock edges after the strobes reach the pins, data_oe_o goes to 1 and data_o carries the last byte committed at that address.
- R3: Whenever data_oe_o is 0, data_o is 0 (the bus is released).
- R4: A write window opens on the clock where the synchronised overlap of low chip enable and low write enable first appears, whichever of the two fell later. It closes on the first clock where either strobe is high again. The byte on data_i is written at the close, to the address latched at the open.
- R5: wr_done_o is high for exactly one cycle per committed write. It rises on the third clock edge after the closing strobe edge reaches the pin.
- R6: If write enable falls while a read is driving the bus, data_oe_o falls three clock edges later. The overlap of chip enable and write enable that follows is treated as a write.
- R7: While wp_i is high, data_oe_o and data_o are 0 in the same cycle. No window opens and no byte is committed.
- R8: If wp_i is high while a window is open, the window is aborted with no commit and no wr_done_o. A new window needs a fresh falling edge of the chip enable and write enable overlap after wp_i has dropped.
- R9: While rst_ni is low, and after it is released, data_oe_o and wr_done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | 17 | Byte address |
| data_i | input | 8 | Write data from the bus |
| wp_i | input | 1 | Write protect from the power supervisor |
| data_o | output | 8 | Read data, 0 when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| wr_done_o | output | 1 | One-cycle write commit strobe |

## Verification
Two events can meet in one clock: write-protect rising and a write window closing. The bench provokes this by raising wp_i on the same clock as write enable rises. It also raises wp_i a few cycles into an open window, and while the window is still open it lowers wp_i again.

The outcome is judged at the ports. No wr_done_o pulse may appear. A later read of that address must return the byte held before the aborted write. Releasing write enable after a dropped protect must not create a write either.

A second pairing is covered as well: write enable falling while a read is still driving the bus. The drive must end on schedule, and the write that follows must land in the array.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int unsigned BUS_AW = 17;
  localparam int unsigned BUS_DW = 8;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;
endpackage

// File: rtl/psram_sync.sv
module psram_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/psram_ram.sv
module psram_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_i,
  output logic              ram_we_o,
  output logic [MEM_AW-1:0] ram_waddr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              rd_en_o,
  output logic              wr_done_o,
  output logic              win_open_o
);
  logic win_act, win_prev, win_q, rd_act, rd_q, done_q;
  logic [MEM_AW-1:0] waddr_q;

  always_comb begin
    win_act = ~stb_i.ce_n & ~stb_i.we_n;
    rd_act  = ~stb_i.ce_n & ~stb_i.oe_n & stb_i.we_n & ~wp_i;
  end

  // open only on a fresh overlap edge; protect aborts before close can commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_prev <= 1'b0;
      win_q    <= 1'b0;
      rd_q     <= 1'b0;
      done_q   <= 1'b0;
      waddr_q  <= '0;
    end else begin
      win_prev <= win_act;
      rd_q     <= rd_act;
      done_q   <= 1'b0;
      if (win_q) begin
        if (wp_i) win_q <= 1'b0;
        else if (!win_act) begin
          win_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (win_act && !win_prev && !wp_i) begin
        win_q   <= 1'b1;
        waddr_q <= addr_i[MEM_AW-1:0];
      end
    end
  end

  assign ram_we_o    = win_q & ~win_act & ~wp_i;
  assign ram_waddr_o = waddr_q;
  assign ram_wdata_o = data_i;
  assign rd_en_o     = rd_q;
  assign wr_done_o   = done_q;
  assign win_open_o  = win_q;
endmodule

// File: rtl/psram_bus_if.sv
module psram_bus_if
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_AW,
  parameter int unsigned DATA_W = BUS_DW,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wr_done_o
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  strobe_t stb_raw, stb_s;
  logic [BUS_W-1:0] bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s, rdata;
  logic ram_we, rd_en, win_open;
  logic [MEM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  assign stb_raw = '{ce_n: ce_ni, we_n: we_ni, oe_n: oe_ni};

  psram_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_stb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stb_raw), .q_o(stb_s)
  );

  // address and data delayed alongside the strobes to stay aligned
  psram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({addr_i, data_i}), .q_o(bus_s)
  );
  assign {addr_s, data_s} = bus_s;

  psram_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_s), .addr_i(addr_s),
    .data_i(data_s), .wp_i(wp_i), .ram_we_o(ram_we), .ram_waddr_o(ram_waddr),
    .ram_wdata_o(ram_wdata), .rd_en_o(rd_en), .wr_done_o(wr_done_o),
    .win_open_o(win_open)
  );

  psram_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(addr_s[MEM_AW-1:0]), .rdata_o(rdata)
  );

  assign data_oe_o = rd_en & ~wp_i;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/psram_bus_chk.sv
module psram_bus_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              wp_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              wr_done_o,
  input logic              win_open
);
  // R7
  wp_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> (!data_oe_o && data_o == '0));
  // R3
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
  // R2
  rd_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ($past(we_ni, 3) && !$past(ce_ni, 3) && !$past(oe_ni, 3)));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);
  // R4
  done_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> ($past(ce_ni, 3) || $past(we_ni, 3)));
  // R8
  wp_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && wp_i) |=> (!win_open && !wr_done_o));
  // R7
  wp_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> !$past(wp_i));
endmodule

bind psram_bus_if psram_bus_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
  .wp_i(wp_i), .data_o(data_o), .data_oe_o(data_oe_o), .wr_done_o(wr_done_o),
  .win_open(win_open)
);

// File: tb/tb_psram_bus_if.sv
`timescale 1ns/1ps
module tb_psram_bus_if;
  localparam int MAW = 10;
  localparam int DEPTH = 1 << MAW;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, wp = 0;
  logic [16:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe, wdone;

  int total = 0, bad = 0, pulses = 0;
  bit finished = 0;
  logic [7:0] ref_mem [DEPTH];
  bit vld [DEPTH];
  logic prev_done = 0;

  always #4 clk = ~clk;

  psram_bus_if #(.MEM_AW(MAW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .wp_i(wp), .data_o(dout), .data_oe_o(doe),
    .wr_done_o(wdone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // strobe width monitor (R5)
  always @(negedge clk) begin
    if (rst_n && wdone) begin
      pulses++;
      if (prev_done) chk("R5 pulse width", 1, 0);
    end
    prev_done = wdone;
  end

  function automatic int idx(logic [16:0] a);
    return int'(a[MAW-1:0]);
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [16:0] a, logic [7:0] d, bit ce_first, bit we_close, bit commit);
    int p0;
    p0 = pulses;
    @(negedge clk);
    addr = a; din = d; oe_n = 1;
    if (ce_first) begin ce_n = 0; wait_n(2); we_n = 0; end
    else          begin we_n = 0; wait_n(2); ce_n = 0; end
    wait_n(3);
    if (we_close) begin we_n = 1; wait_n(2); ce_n = 1; end
    else          begin ce_n = 1; wait_n(2); we_n = 1; end
    wait_n(5);
    if (commit) begin
      ref_mem[idx(a)] = d; vld[idx(a)] = 1;
      chk("R4 R5 one strobe per write", pulses - p0, 1);
    end else chk("R7 no strobe under protect", pulses - p0, 0);
  endtask

  task automatic do_read(logic [16:0] a, string req);
    @(negedge clk);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    wait_n(4);
    chk({req, " drive"}, doe, 1);
    if (vld[idx(a)]) chk({req, " data"}, dout, ref_mem[idx(a)]);
    ce_n = 1; oe_n = 1;
    wait_n(4);
    chk("R3 released", {doe, dout}, 0);
  endtask

  initial begin
    int p0;
    logic [16:0] a;
    for (int i = 0; i < DEPTH; i++) vld[i] = 0;
    wait_n(3);
    // R9
    chk("R9 reset oe", doe, 0);
    chk("R9 reset done", wdone, 0);
    rst_n = 1;
    wait_n(4);
    chk("R9 post-reset", {doe, wdone}, 0);

    // R4 orderings
    do_write(17'h00010, 8'hA5, 1, 1, 1);
    do_write(17'h00011, 8'h3C, 0, 0, 1);
    do_write(17'h00012, 8'h77, 1, 0, 1);
    do_write(17'h00013, 8'hE1, 0, 1, 1);
    do_read(17'h00010, "R4");
    do_read(17'h00011, "R4");
    do_read(17'h00012, "R4");
    do_read(17'h00013, "R4");

    // R1 aliasing: bit 12 is above MEM_AW
    do_write(17'h01013, 8'h5B, 1, 1, 1);
    do_read(17'h00013, "R1 alias");

    // R2 exact latency
    @(negedge clk);
    addr = 17'h00010; ce_n = 0; oe_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 not yet", doe, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 drive at 3rd edge", doe, 1);
    chk("R2 data", dout, 8'hA5);
    // R7 protect floats at once
    wp = 1; #1;
    chk("R7 float", {doe, dout}, 0);
    @(negedge clk); wp = 0;
    wait_n(3);
    chk("R2 back after protect", doe, 1);
    // R6 write enable falling kills drive, then writes
    din = 8'hC3; we_n = 0; oe_n = 1;
    oe_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 still on", doe, 1);
    @(posedge clk); @(negedge clk);
    chk("R6 off", doe, 0);
    p0 = pulses;
    wait_n(2); we_n = 1;
    // R5 exact strobe timing
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not yet", wdone, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 strobe", wdone, 1);
    @(negedge clk);
    chk("R5 single", wdone, 0);
    ce_n = 1; oe_n = 1;
    ref_mem[idx(17'h00010)] = 8'hC3;
    chk("R6 write lands count", pulses - p0, 1);
    wait_n(4);
    do_read(17'h00010, "R6");

    // R7 whole write under protect
    @(negedge clk); wp = 1;
    do_write(17'h00011, 8'h00, 1, 1, 0);
    @(negedge clk); wp = 0;
    do_read(17'h00011, "R7");

    // R8 protect rising with the close edge
    p0 = pulses;
    @(negedge clk);
    addr = 17'h00012; din = 8'h99; ce_n = 0; wait_n(2); we_n = 0;
    wait_n(4);
    we_n = 1; wp = 1;
    wait_n(2); ce_n = 1; wait_n(4); wp = 0; wait_n(2);
    chk("R8 same-cycle abort", pulses - p0, 0);
    do_read(17'h00012, "R8");

    // R8 protect mid-window, dropped before release
    p0 = pulses;
    @(negedge clk);
    addr = 17'h00013; din = 8'h11; we_n = 0; wait_n(2); ce_n = 0;
    wait_n(4); wp = 1; wait_n(3); wp = 0; wait_n(4);
    ce_n = 1; wait_n(2); we_n = 1; wait_n(5);
    chk("R8 no reopen", pulses - p0, 0);
    do_read(17'h00013, "R8");

    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 150; k++) begin
      a = 17'(($urandom % 24) | (($urandom % 4) << 10));
      if ($urandom % 2) do_write(a, 8'($urandom), 1'($urandom), 1'($urandom), 1);
      else              do_read(a, "R2 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule